// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit performs one packed-decimal (two BCD digits per byte) operation per accepted strobe: an add that folds in the incoming extend bit, a subtract that takes the extend bit away, or a negate that subtracts the source and extend bit from zero. A caller processing a multi-byte decimal number feeds the bytes one per strobe, least significant first. It passes the extend output of one byte back in as the extend input of the next, and the zero output back in as the zero input. In this way a borrow or carry runs along the chain, and the zero flag reports on the whole number.

The result and flags are registered and appear one clock after the strobe. Digit values above 9 are not rejected. They pass through the same correction rules as legal digits, so the outputs stay predictable for any byte pattern. The extend and carry outputs always carry the same value. The overflow flag compares the sign bit of the raw binary result with the sign bit of the corrected result.

Top module: `bcd_byte_alu`

## Requirements
- R1: While rst_ni is low, res_o, all five flag outputs and valid_o are 0.
- R2: When valid_i is high and op_i is 00, 01 or 10, res_o and the flags reflect that operation on the next clock and valid_o is 1 for that cycle. When valid_i is low, res_o and all flags hold their values and valid_o is 0.
- R3: With op_i = 00 (add), the low partial is dst_i[3:0] + src_i[3:0] + x_i, plus 6 if it exceeds 9. The high digits of both operands (times 16) are added to it. If that total exceeds 0x9F, 0x60 is added, and res_o is bits 7:0 of the final total.
- R4: For add, x_o and c_o are both 1 exactly when the final total of R3 is 0x100 or more. If both operands are below 0x40, no carry is produced.
- R5: For add, v_o is 1 exactly when bit 7 of the raw binary sum dst_i + src_i + x_i is 0 and bit 7 of res_o is 1.
- R6: With op_i = 01 (subtract), let raw = dst_i - src_i - x_i and low = dst_i[3:0] - src_i[3:0] - x_i, both as signed integers. Let fix = 6 when low < 0, else 0. The high part is the difference of the high digits (times 16), minus 0x60 when raw < 0. res_o is bits 7:0 of low + high - fix.
- R7: For subtract, x_o and c_o are both 1 exactly when (raw - fix), in two's complement, has bit 8 or bit 9 set.
- R8: For subtract, v_o is 1 exactly when bit 7 of raw is 1 and bit 7 of res_o is 0.
- R9: With op_i = 10 (negate), every output equals that of subtract with dst_i taken as 0. Negating 0 with x_i = 0 gives 0 with no carry.
- R10: z_o is z_i AND (res_o == 0). A nonzero result clears it, and a zero result passes z_i through unchanged.
- R11: n_o equals bit 7 of res_o after every accepted operation.
- R12: A strobe with op_i = 11 is ignored. res_o and the flags keep their values, and valid_o is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 00 add, 01 subtract, 10 negate, 11 reserved |
| dst_i | input | 8 | Destination operand (minuend for subtract) |
| src_i | input | 8 | Source operand |
| x_i | input | 1 | Incoming extend bit |
| z_i | input | 1 | Incoming zero flag of the chain |
| res_o | output | 8 | Corrected result byte |
| x_o | output | 1 | Extend out |
| c_o | output | 1 | Carry or borrow out |
| z_o | output | 1 | Sticky zero flag |
| n_o | output | 1 | Bit 7 of the result |
| v_o | output | 1 | Overflow |
| valid_o | output | 1 | Result strobe, one cycle after an accepted strobe |

## Verification
The hardest cases to reach are bytes where the two correction steps interact. Examples are a subtract whose low-digit borrow combines with the high-part correction to set bit 9 but not bit 8, and an add where only the second adjustment pushes the total past eight bits. Hand-picked decimal operands rarely produce these. The stimulus therefore sweeps a coarse grid over all byte values, including invalid digits, for every operation and both extend values, and then adds random operands. Chained sequences feed x_o and z_o back into the next strobe, so the sticky-zero path is exercised both with a zero result and with a nonzero one.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int WIDE_W = BYTE_W + 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_NEG = 2'b10,
    OP_RSV = 2'b11
  } bcd_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] res;
    logic              x;
    logic              c;
    logic              z;
    logic              n;
    logic              v;
  } bcd_out_t;
endpackage

// File: rtl/bcd_add_core.sv
module bcd_add_core
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              x_i,
  input  logic              z_i,
  output bcd_out_t          out_o
);
  localparam logic [WIDE_W-1:0] LO_LIM = WIDE_W'(9);
  localparam logic [WIDE_W-1:0] LO_FIX = WIDE_W'(6);
  localparam logic [WIDE_W-1:0] HI_LIM = WIDE_W'(16'h009f);
  localparam logic [WIDE_W-1:0] HI_FIX = WIDE_W'(16'h0060);

  logic [WIDE_W-1:0] raw, lo, lo_c, tot, tot_c;

  always_comb begin
    raw   = WIDE_W'(a_i) + WIDE_W'(b_i) + WIDE_W'(x_i);
    lo    = WIDE_W'(a_i[NIB_W-1:0]) + WIDE_W'(b_i[NIB_W-1:0]) + WIDE_W'(x_i);
    lo_c  = (lo > LO_LIM) ? lo + LO_FIX : lo;
    tot   = lo_c + WIDE_W'({a_i[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
                 + WIDE_W'({b_i[BYTE_W-1:NIB_W], {NIB_W{1'b0}}});
    tot_c = (tot > HI_LIM) ? tot + HI_FIX : tot;
    out_o.res = tot_c[BYTE_W-1:0];
    out_o.x   = |tot_c[WIDE_W-1:BYTE_W];
    out_o.c   = |tot_c[WIDE_W-1:BYTE_W];
    out_o.z   = z_i & (tot_c[BYTE_W-1:0] == '0);
    out_o.n   = tot_c[BYTE_W-1];
    out_o.v   = ~raw[BYTE_W-1] & tot_c[BYTE_W-1];
  end
endmodule

// File: rtl/bcd_sub_core.sv
module bcd_sub_core
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              x_i,
  input  logic              z_i,
  output bcd_out_t          out_o
);
  localparam logic [WIDE_W-1:0] LO_FIX = WIDE_W'(6);
  localparam logic [WIDE_W-1:0] HI_FIX = WIDE_W'(16'h0060);

  // Two's complement at WIDE_W bits; bit WIDE_W-1 is the sign.
  logic [WIDE_W-1:0] raw, lo, fix_lo, hi, res, chk;

  always_comb begin
    raw    = WIDE_W'(a_i) - WIDE_W'(b_i) - WIDE_W'(x_i);
    lo     = WIDE_W'(a_i[NIB_W-1:0]) - WIDE_W'(b_i[NIB_W-1:0]) - WIDE_W'(x_i);
    fix_lo = lo[WIDE_W-1] ? LO_FIX : '0;
    hi     = WIDE_W'({a_i[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
           - WIDE_W'({b_i[BYTE_W-1:NIB_W], {NIB_W{1'b0}}})
           - (raw[WIDE_W-1] ? HI_FIX : '0);
    res    = lo + hi - fix_lo;
    chk    = raw - fix_lo;
    out_o.res = res[BYTE_W-1:0];
    out_o.x   = |chk[BYTE_W+1:BYTE_W];
    out_o.c   = |chk[BYTE_W+1:BYTE_W];
    out_o.z   = z_i & (res[BYTE_W-1:0] == '0);
    out_o.n   = res[BYTE_W-1];
    out_o.v   = raw[BYTE_W-1] & ~res[BYTE_W-1];
  end
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
  import bcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [BYTE_W-1:0] dst_i,
  input  logic [BYTE_W-1:0] src_i,
  input  logic              x_i,
  input  logic              z_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              x_o,
  output logic              c_o,
  output logic              z_o,
  output logic              n_o,
  output logic              v_o,
  output logic              valid_o
);
  bcd_op_e           op;
  bcd_out_t          add_out, sub_out, sel_out, out_q;
  logic [BYTE_W-1:0] minuend;
  logic              accept, vld_q;

  assign op      = bcd_op_e'(op_i);
  assign minuend = (op == OP_NEG) ? '0 : dst_i;   // negate = subtract from zero
  assign accept  = valid_i & (op != OP_RSV);

  bcd_add_core u_add (
    .a_i(dst_i), .b_i(src_i), .x_i(x_i), .z_i(z_i), .out_o(add_out)
  );

  bcd_sub_core u_sub (
    .a_i(minuend), .b_i(src_i), .x_i(x_i), .z_i(z_i), .out_o(sub_out)
  );

  assign sel_out = (op == OP_ADD) ? add_out : sub_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= accept;
      if (accept) out_q <= sel_out;
    end
  end

  assign res_o   = out_q.res;
  assign x_o     = out_q.x;
  assign c_o     = out_q.c;
  assign z_o     = out_q.z;
  assign n_o     = out_q.n;
  assign v_o     = out_q.v;
  assign valid_o = vld_q;

  a_r10_z_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !z_i) |=> !z_o);

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(z_o) && $stable(c_o) && !valid_o));

  a_r12_rsv_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b11) |=> ($stable(res_o) && $stable(x_o) && !valid_o));

  a_r4_add_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b00 && dst_i < 8'h40 && src_i < 8'h40) |=> (!c_o && !x_o));

  a_r9_neg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10 && src_i == '0 && !x_i) |=> (res_o == '0 && !c_o && valid_o));
endmodule

// File: tb/bcd_byte_alu_tb.sv
module bcd_byte_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] dst = '0, src = '0;
  logic       x_in = 1'b0, z_in = 1'b0;
  logic [7:0] res;
  logic       xo, co, zo, no, vo, vo_s;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // expected state
  logic [12:0] exp_q = '0;   // {res,x,c,z,n,v}
  logic        exp_vld = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_byte_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .dst_i(dst), .src_i(src), .x_i(x_in), .z_i(z_in),
    .res_o(res), .x_o(xo), .c_o(co), .z_o(zo), .n_o(no), .v_o(vo),
    .valid_o(vo_s)
  );

  function automatic logic [12:0] model(int o, int d, int s, int x, int z);
    int r, cy, ov, ub, lo, la, hi, t;
    if (o == 0) begin
      lo = d % 16 + s % 16 + x;
      if (lo > 9) lo += 6;
      t = lo + (d / 16) * 16 + (s / 16) * 16;
      if (t > 159) t += 96;
      r  = t;
      cy = (t > 255) ? 1 : 0;
      ov = (((d + s + x) & 128) == 0 && (t & 128) != 0) ? 1 : 0;
    end else begin
      if (o == 2) d = 0;
      ub = d - s - x;
      lo = d % 16 - s % 16 - x;
      la = (lo < 0) ? 6 : 0;
      hi = (d / 16) * 16 - (s / 16) * 16 - ((ub < 0) ? 96 : 0);
      r  = lo + hi - la;
      cy = (((ub - la) & 'h300) != 0) ? 1 : 0;
      ov = ((ub & 128) != 0 && (r & 128) == 0) ? 1 : 0;
    end
    model = {r[7:0], cy[0], cy[0], (z != 0 && (r & 255) == 0), r[7], ov[0]};
  endfunction

  task automatic check(string tag);
    logic [12:0] act;
    act = {res, xo, co, zo, no, vo};
    checks++;
    if (act !== exp_q || vo_s !== exp_vld) begin
      failures++;
      $display("FAIL %s: got res/x/c/z/n/v=%h valid=%b, expected %h valid=%b",
               tag, act, vo_s, exp_q, exp_vld);
    end
  endtask

  // called at a negedge; leaves at the next negedge after checking
  task automatic step(bit v, int o, int d, int s, int x, int z, string tag);
    valid = v; op = o[1:0]; dst = d[7:0]; src = s[7:0]; x_in = x[0]; z_in = z[0];
    if (v && o != 3) begin
      exp_q   = model(o, d, s, x, z);
      exp_vld = 1'b1;
    end else exp_vld = 1'b0;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        done = 1;
        failures++;
        $display("FAIL watchdog: got %0d cycles, expected under %0d", cycles, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int zc;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // add cases
    step(1, 0, 'h45, 'h38, 0, 1, "R3 R5 add 45+38");
    step(1, 0, 'h99, 'h01, 0, 1, "R4 R10 add 99+01 carry, zero kept");
    step(1, 0, 'h99, 'h99, 1, 1, "R4 add 99+99+x");
    step(1, 0, 'h3f, 'h3f, 1, 0, "R4 add invalid digits below 40");
    step(0, 0, 'h12, 'h34, 0, 0, "R2 idle hold");
    // subtract cases
    step(1, 1, 'h50, 'h01, 0, 1, "R6 R7 sub 50-01");
    step(1, 1, 'h00, 'h01, 0, 1, "R7 R11 sub borrow");
    step(1, 1, 'h80, 'h01, 0, 1, "R8 sub 80-01");
    step(1, 1, 'h25, 'h25, 1, 1, "R6 R7 sub with x");
    // negate
    step(1, 2, 'hff, 'h00, 0, 1, "R9 neg zero");
    step(1, 2, 'h77, 'h01, 0, 1, "R9 neg 01");
    step(1, 2, 'h00, 'h00, 1, 0, "R9 neg x only");
    // reserved
    step(1, 3, 'h11, 'h22, 1, 0, "R12 reserved op");
    // chained sticky zero: 0100 - 0100 in two bytes
    step(1, 1, 'h00, 'h00, 0, 1, "R10 chain low byte zero");
    zc = zo; 
    step(1, 1, 'h01, 'h01, xo, zc, "R10 chain high byte zero");
    step(1, 0, 'h00, 'h00, 0, 0, "R10 zero result keeps cleared z");
    step(1, 0, 'h00, 'h01, 0, 1, "R10 nonzero clears z");

    // coarse sweep
    for (int o = 0; o < 3; o++)
      for (int d = 0; d < 256; d += 9)
        for (int s = 0; s < 256; s += 11)
          for (int x = 0; x < 2; x++)
            step(1, o, d, s, x, (d + s) & 1,
                 o == 0 ? "R3 R4 R5 R11 sweep" : (o == 1 ? "R6 R7 R8 sweep" : "R9 sweep"));
    // random, with idle and reserved mixed in
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 5) != 0, $urandom_range(0, 3), $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 1),
           "R2 R10 R12 random");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule